// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block moves packet data from memory to a stream port by following a chain of descriptors. Each descriptor is a 56-byte record in little-endian memory. It holds a link to the next record, a buffer address, a control word with the buffer length and the packet-boundary flags, a status word, and six user words that belong to the packet. The register file supplies a current pointer, a tail pointer, a run enable and an idle flag. A start pulse launches a walk. The walker reads each record through a word-wide memory master port and sends the buffer bytes out as stream beats. It then writes the status word back as complete and passes the link pointer back to the register file. The walk ends at the tail record, or earlier at a record whose status already shows it as complete.

The controller is one state machine with these states: `ST_IDLE`, `ST_DESC`, `ST_CHECK`, `ST_USER`, `ST_READ`, `ST_EMIT`, `ST_WBACK` and `ST_ADV`. The transitions are:

- `ST_IDLE` to `ST_DESC` on an accepted start.
- `ST_DESC` to `ST_CHECK` after the fourth header word.
- `ST_CHECK` to `ST_IDLE` when the record is already complete. Otherwise it goes to `ST_USER` on a start-of-frame record, to `ST_WBACK` on a zero length, and to `ST_READ` in every other case.
- `ST_USER` to `ST_READ` or `ST_WBACK` after the sixth user word.
- `ST_READ` to `ST_EMIT` on the read acknowledge.
- `ST_EMIT` to `ST_READ` on a beat that is not the last one, and to `ST_WBACK` on the last beat.
- `ST_WBACK` to `ST_ADV` on the write acknowledge.
- `ST_ADV` to `ST_IDLE` at the tail, and to `ST_DESC` otherwise.

Top module: `sgw_walker`

## Requirements
- R1: While reset is held, and after it is released, the walker makes no memory request, presents no stream beat, and holds the completion, set-idle and pointer-update outputs low.
- R2: A start pulse is ignored unless the run enable is high and the idle flag is low. An ignored start produces no memory request.
- R3: A walk step reads four little-endian header words relative to the record base: the link pointer at +0x00, the buffer address at +0x08, control at +0x18 and status at +0x1C. Each request keeps its address, direction and write data unchanged until it is acknowledged.
- R4: If the fetched status word has bit 31 set, the walker pulses set-idle for one cycle and stops. It sends no beat for that record and writes nothing to it.
- R5: When control bit 27 (start of frame) is set, the walker reads six user words at +0x20 through +0x34 and shows them on `user_o` in word order. The packet byte count restarts at zero.
- R6: Buffer bytes leave four per beat with the lowest address in `m_tdata_o[7:0]`. `m_tkeep_o` is all ones except on the final beat of a buffer, where it keeps only the low lanes that hold data. `m_tlast_o` is set only on the final beat of a buffer whose control bit 26 (end of frame) is set. The buffer length is control bits 22:0, in bytes. Buffers are word-aligned.
- R7: While a beat is offered and not taken, valid, data, keep and last stay unchanged.
- R8: After the buffer, the walker writes the status word at +0x1C. Bits 22:0 hold the length and bit 31 is set.
- R9: After the write-back, `cur_ptr_we_o` pulses for one cycle with `cur_ptr_o` equal to the record's link pointer.
- R10: If the record just finished lies at the tail pointer, set-idle pulses in that same cycle and the walker stops. Otherwise it fetches the record at the link pointer.
- R11: For an end-of-frame record, `done_o` pulses for exactly one cycle, together with the pointer update. `pkt_bytes_o` then shows the bytes sent since the last start of frame.
- R12: A zero-length record sends no beat, but its status is still written back as complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a walk |
| run_en_i | input | 1 | Channel run enable from the register file |
| idle_i | input | 1 | Channel idle flag from the register file |
| cur_ptr_i | input | ADDR_W | Record address where the walk begins |
| tail_ptr_i | input | ADDR_W | Address of the last record to process |
| cur_ptr_o | output | ADDR_W | Updated current pointer |
| cur_ptr_we_o | output | 1 | Strobe for `cur_ptr_o` |
| set_idle_o | output | 1 | Pulse asking the register file to set idle |
| done_o | output | 1 | Packet completion pulse |
| pkt_bytes_o | output | POS_W | Byte count of the packet, valid with `done_o` |
| user_o | output | USER_N*32 | User words latched at start of frame |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address, word-aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tdata_o | output | 32 | Stream data |
| m_tkeep_o | output | 4 | Stream byte enables |
| m_tlast_o | output | 1 | End of packet |

## Verification
The main function is tried on several chains:

- A single record that holds a whole packet with an odd length. This separates the partial-beat keep from the full-beat case.
- A three-record packet under a periodic ready stall. This exposes beats that are lost or repeated, and a byte count that does not carry across records.
- A chain that runs into a record that is already complete. This tells the early stop apart from the tail stop.
- A zero-length record ahead of a three-byte packet.
- Two packets in one chain. This shows whether the byte count and the user words restart at each start of frame.

Memory latency changes from access to access, so the hold of every request is exercised.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    // Record layout offsets (bytes from the record base)
    localparam logic [7:0] OFS_LINK = 8'h00;
    localparam logic [7:0] OFS_BUF  = 8'h08;
    localparam logic [7:0] OFS_CTRL = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h1C;
    localparam logic [7:0] OFS_USER = 8'h20;

    // Flag positions inside control and status
    localparam int CTL_EOF_BIT  = 26;
    localparam int CTL_SOF_BIT  = 27;
    localparam int STAT_CPL_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_CHECK,
        ST_USER,
        ST_READ,
        ST_EMIT,
        ST_WBACK,
        ST_ADV
    } sgw_state_e;

    // Header word fetched in step idx of ST_DESC
    function automatic logic [7:0] hdr_ofs(input logic [1:0] idx);
        logic [7:0] r;
        unique case (idx)
            2'd0: r = OFS_LINK;
            2'd1: r = OFS_BUF;
            2'd2: r = OFS_CTRL;
            default: r = OFS_STAT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sgw_beat_calc.sv
module sgw_beat_calc #(
    parameter int LEN_W  = 23,
    parameter int LANES  = 4,
    parameter int TAKE_W = $clog2(LANES) + 1
) (
    input  logic [LEN_W-1:0]  left_i,
    output logic [LANES-1:0]  keep_o,
    output logic              final_o,
    output logic [TAKE_W-1:0] take_o
);

    // One lane is valid for each byte still left, filled from lane 0 up
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign keep_o[i] = (left_i > LEN_W'(i));
        end
    endgenerate

    assign final_o = (left_i <= LEN_W'(LANES));
    assign take_o  = final_o ? left_i[TAKE_W-1:0] : TAKE_W'(LANES);

endmodule

// File: rtl/sgw_user_bank.sv
module sgw_user_bank #(
    parameter int USER_N = 6,
    parameter int WORD_W = 32,
    parameter int IDX_W  = (USER_N > 1) ? $clog2(USER_N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         wr_idx_i,
    input  logic [WORD_W-1:0]        wr_data_i,
    output logic [USER_N*WORD_W-1:0] words_o
);

    generate
        for (genvar i = 0; i < USER_N; i++) begin : g_word
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                    word_q <= wr_data_i;
                end
            end
            assign words_o[i*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 23,
    parameter int USER_N = 6,
    parameter int POS_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     run_en_i,
    input  logic                     idle_i,
    input  logic [ADDR_W-1:0]        cur_ptr_i,
    input  logic [ADDR_W-1:0]        tail_ptr_i,
    output logic [ADDR_W-1:0]        cur_ptr_o,
    output logic                     cur_ptr_we_o,
    output logic                     set_idle_o,
    output logic                     done_o,
    output logic [POS_W-1:0]         pkt_bytes_o,
    output logic [USER_N*DATA_W-1:0] user_o,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic [DATA_W-1:0]        mem_wdata_o,
    input  logic                     mem_ack_i,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    output logic                     m_tvalid_o,
    input  logic                     m_tready_i,
    output logic [DATA_W-1:0]        m_tdata_o,
    output logic [LANES-1:0]         m_tkeep_o,
    output logic                     m_tlast_o
);

    localparam int IDX_W  = (USER_N > 1) ? $clog2(USER_N) : 1;
    localparam int TAKE_W = $clog2(LANES) + 1;

    sgw_state_e state_q, state_d;

    logic [1:0]        hdr_idx_q;
    logic [IDX_W-1:0]  usr_idx_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  left_q;
    logic              sof_q;
    logic              eof_q;
    logic              cpl_q;
    logic [DATA_W-1:0] beat_q;
    logic [POS_W-1:0]  pos_q;

    logic [LANES-1:0]  keep_w;
    logic              final_w;
    logic [TAKE_W-1:0] take_w;
    logic              launch_w;
    logic              at_tail_w;
    logic              usr_last_w;
    logic              usr_wr_w;

    assign launch_w   = start_i && run_en_i && !idle_i;
    assign at_tail_w  = (cur_q == tail_ptr_i);
    assign usr_last_w = (usr_idx_q == IDX_W'(USER_N - 1));
    assign usr_wr_w   = (state_q == ST_USER) && mem_ack_i;

    sgw_beat_calc #(
        .LEN_W (LEN_W),
        .LANES (LANES)
    ) u_calc (
        .left_i  (left_q),
        .keep_o  (keep_w),
        .final_o (final_w),
        .take_o  (take_w)
    );

    sgw_user_bank #(
        .USER_N (USER_N),
        .WORD_W (DATA_W)
    ) u_user (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (usr_wr_w),
        .wr_idx_i  (usr_idx_q),
        .wr_data_i (mem_rdata_i),
        .words_o   (user_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_w) state_d = ST_DESC;
            end
            ST_DESC: begin
                if (mem_ack_i && (hdr_idx_q == 2'd3)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (cpl_q)              state_d = ST_IDLE;
                else if (sof_q)         state_d = ST_USER;
                else if (len_q == '0)   state_d = ST_WBACK;
                else                    state_d = ST_READ;
            end
            ST_USER: begin
                if (mem_ack_i && usr_last_w)
                    state_d = (len_q == '0) ? ST_WBACK : ST_READ;
            end
            ST_READ: begin
                if (mem_ack_i) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (m_tready_i) state_d = final_w ? ST_WBACK : ST_READ;
            end
            ST_WBACK: begin
                if (mem_ack_i) state_d = ST_ADV;
            end
            ST_ADV: begin
                state_d = at_tail_w ? ST_IDLE : ST_DESC;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_idx_q <= '0;
            usr_idx_q <= '0;
            cur_q     <= '0;
            link_q    <= '0;
            buf_q     <= '0;
            len_q     <= '0;
            left_q    <= '0;
            sof_q     <= 1'b0;
            eof_q     <= 1'b0;
            cpl_q     <= 1'b0;
            beat_q    <= '0;
            pos_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_w) begin
                        cur_q     <= cur_ptr_i;
                        hdr_idx_q <= '0;
                    end
                end
                ST_DESC: begin
                    if (mem_ack_i) begin
                        hdr_idx_q <= hdr_idx_q + 2'd1;
                        unique case (hdr_idx_q)
                            2'd0: link_q <= mem_rdata_i[ADDR_W-1:0];
                            2'd1: buf_q  <= mem_rdata_i[ADDR_W-1:0];
                            2'd2: begin
                                len_q  <= mem_rdata_i[LEN_W-1:0];
                                left_q <= mem_rdata_i[LEN_W-1:0];
                                sof_q  <= mem_rdata_i[CTL_SOF_BIT];
                                eof_q  <= mem_rdata_i[CTL_EOF_BIT];
                            end
                            default: cpl_q <= mem_rdata_i[STAT_CPL_BIT];
                        endcase
                    end
                end
                ST_CHECK: begin
                    usr_idx_q <= '0;
                    if (!cpl_q && sof_q) pos_q <= '0;
                end
                ST_USER: begin
                    if (mem_ack_i) usr_idx_q <= usr_idx_q + IDX_W'(1);
                end
                ST_READ: begin
                    if (mem_ack_i) beat_q <= mem_rdata_i;
                end
                ST_EMIT: begin
                    if (m_tready_i) begin
                        left_q <= left_q - LEN_W'(take_w);
                        buf_q  <= buf_q + ADDR_W'(LANES);
                        pos_q  <= pos_q + POS_W'(take_w);
                    end
                end
                ST_ADV: begin
                    cur_q     <= link_q;
                    hdr_idx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        m_tvalid_o   = 1'b0;
        m_tlast_o    = 1'b0;
        cur_ptr_we_o = 1'b0;
        set_idle_o   = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_DESC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + ADDR_W'(hdr_ofs(hdr_idx_q));
            end
            ST_CHECK: begin
                set_idle_o = cpl_q;
            end
            ST_USER: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + ADDR_W'(OFS_USER) + (ADDR_W'(usr_idx_q) << 2);
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = buf_q;
            end
            ST_EMIT: begin
                m_tvalid_o = 1'b1;
                m_tlast_o  = eof_q && final_w;
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cur_q + ADDR_W'(OFS_STAT);
                mem_wdata_o = DATA_W'(len_q);
                mem_wdata_o[STAT_CPL_BIT] = 1'b1;
            end
            ST_ADV: begin
                cur_ptr_we_o = 1'b1;
                done_o       = eof_q;
                set_idle_o   = at_tail_w;
            end
            default: ;
        endcase
    end

    assign cur_ptr_o   = link_q;
    assign pkt_bytes_o = pos_q;
    assign m_tdata_o   = beat_q;
    assign m_tkeep_o   = keep_w;

    // Checks beside the logic they guard
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o)); // R3

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o)
                                      && $stable(m_tkeep_o) && $stable(m_tlast_o)); // R7

    AST_KEEP_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid_o |-> (m_tkeep_o inside {4'h1, 4'h3, 4'h7, 4'hF})); // R6

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        set_idle_o |=> !mem_req_o && !m_tvalid_o && !set_idle_o); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_DONE_WITH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cur_ptr_we_o); // R11

endmodule

// File: tb/sgw_walker_tb_top.sv
module sgw_walker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 23;
    localparam int UN = 6;
    localparam int PW = 16;
    localparam int MEMW = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            start = 1'b0;
    logic            run_reg = 1'b0;
    logic            idle_reg = 1'b0;
    logic [AW-1:0]   cur_reg = '0;
    logic [AW-1:0]   tail_reg = '0;
    logic [AW-1:0]   cur_ptr_o;
    logic            cur_ptr_we_o;
    logic            set_idle_o;
    logic            done_o;
    logic [PW-1:0]   pkt_bytes_o;
    logic [UN*32-1:0] user_o;
    logic            mem_req_o;
    logic            mem_we_o;
    logic [AW-1:0]   mem_addr_o;
    logic [31:0]     mem_wdata_o;
    logic            mem_ack = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic            m_tvalid_o;
    logic            m_tready = 1'b1;
    logic [31:0]     m_tdata_o;
    logic [3:0]      m_tkeep_o;
    logic            m_tlast_o;

    sgw_walker #(.ADDR_W(AW), .LEN_W(LW), .USER_N(UN), .POS_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .run_en_i(run_reg), .idle_i(idle_reg),
        .cur_ptr_i(cur_reg), .tail_ptr_i(tail_reg), .cur_ptr_o(cur_ptr_o),
        .cur_ptr_we_o(cur_ptr_we_o), .set_idle_o(set_idle_o), .done_o(done_o),
        .pkt_bytes_o(pkt_bytes_o), .user_o(user_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .m_tvalid_o(m_tvalid_o),
        .m_tready_i(m_tready), .m_tdata_o(m_tdata_o), .m_tkeep_o(m_tkeep_o),
        .m_tlast_o(m_tlast_o)
    );

    logic [31:0] mem  [0:MEMW-1];
    logic [31:0] smem [0:MEMW-1];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int req_cycles = 0;
    int exp_idle = 0;
    int seen_idle = 0;
    int lat_cnt = 0;
    int lat_target = 0;
    bit bp_mode = 1'b0;
    bit finished = 1'b0;

    logic [31:0]    q_bdata[$];
    logic [3:0]     q_bkeep[$];
    logic           q_blast[$];
    logic [31:0]    q_waddr[$];
    logic [31:0]    q_wdata[$];
    logic [31:0]    q_ptr[$];
    logic [PW-1:0]  q_dbytes[$];
    logic [UN*32-1:0] q_duser[$];

    logic [UN*32-1:0] mdl_user = '0;
    int               mdl_pos = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] k);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = k[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    // Behavioural walk over a shadow of memory, producing expected events
    task automatic predict(input logic [31:0] head, input logic [31:0] tail);
        logic [31:0] cur;
        cur = head;
        for (int guard = 0; guard < 64; guard++) begin
            int ci;
            logic [31:0] nxt, bufa, ctl, st;
            int len;
            ci   = int'(cur[11:2]);
            nxt  = smem[ci];
            bufa = smem[ci + 2];
            ctl  = smem[ci + 6];
            st   = smem[ci + 7];
            if (st[31]) begin
                exp_idle++;
                return;
            end
            if (ctl[27]) begin
                mdl_pos = 0;
                for (int k = 0; k < UN; k++) mdl_user[k*32 +: 32] = smem[ci + 8 + k];
            end
            len = int'(ctl[22:0]);
            for (int b = 0; b < len; b += 4) begin
                int n;
                n = (len - b >= 4) ? 4 : (len - b);
                q_bdata.push_back(smem[int'(bufa[11:2]) + b / 4]);
                q_bkeep.push_back(4'((1 << n) - 1));
                q_blast.push_back(ctl[26] && (b + 4 >= len));
            end
            mdl_pos += len;
            q_waddr.push_back(cur + 32'h1C);
            q_wdata.push_back({1'b1, 8'h00, ctl[22:0]});
            smem[ci + 7] = {1'b1, 8'h00, ctl[22:0]};
            if (ctl[26]) begin
                q_dbytes.push_back(PW'(mdl_pos));
                q_duser.push_back(mdl_user);
            end
            q_ptr.push_back(nxt);
            if (cur == tail) begin
                exp_idle++;
                return;
            end
            cur = nxt;
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] bufa,
                            input logic [31:0] ctl, input logic [31:0] st, input logic [7:0] useed);
        int ci;
        ci = int'(a[11:2]);
        mem[ci]     = nxt;
        mem[ci + 1] = 32'h0;
        mem[ci + 2] = bufa;
        mem[ci + 3] = 32'h0;
        mem[ci + 4] = 32'h0;
        mem[ci + 5] = 32'h0;
        mem[ci + 6] = ctl;
        mem[ci + 7] = st;
        for (int k = 0; k < UN; k++) mem[ci + 8 + k] = {useed, 8'(k), 16'hC0DE};
    endtask

    task automatic fill_buf(input logic [31:0] a, input int len, input logic [7:0] seed);
        for (int w = 0; w < (len + 3) / 4; w++)
            mem[int'(a[11:2]) + w] = {seed + 8'(4*w+3), seed + 8'(4*w+2), seed + 8'(4*w+1), seed + 8'(4*w)};
    endtask

    function automatic logic [31:0] ctl_word(input bit sof, input bit eof, input int len);
        logic [31:0] c;
        c = 32'(len) & 32'h007F_FFFF;
        c[27] = sof;
        c[26] = eof;
        return c;
    endfunction

    task automatic run_chain(input logic [31:0] head, input logic [31:0] tail, input bit bp);
        for (int i = 0; i < MEMW; i++) smem[i] = mem[i];
        predict(head, tail);
        bp_mode  = bp;
        cur_reg  = head;
        tail_reg = tail;
        idle_reg = 1'b0;
        run_reg  = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (seen_idle < exp_idle) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(q_bdata.size() == 0, "R6", "beats left unsent", 256'(q_bdata.size()), 256'd0);
        chk(q_waddr.size() == 0, "R8", "write-backs missing", 256'(q_waddr.size()), 256'd0);
        chk(q_ptr.size() == 0, "R9", "pointer updates missing", 256'(q_ptr.size()), 256'd0);
        chk(q_dbytes.size() == 0, "R11", "completions missing", 256'(q_dbytes.size()), 256'd0);
        chk(!mem_req_o && !m_tvalid_o, "R10", "walker quiet after stop",
            256'({mem_req_o, m_tvalid_o}), 256'd0);
    endtask

    // Memory responder, ready driver and event monitor: one process per negedge
    logic        prev_stall = 1'b0;
    logic [37:0] prev_beat = '0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (prev_stall)
                chk(m_tvalid_o && ({m_tdata_o, m_tkeep_o, m_tlast_o, m_tvalid_o} == prev_beat),
                    "R7", "stalled beat changed",
                    256'({m_tdata_o, m_tkeep_o, m_tlast_o, m_tvalid_o}), 256'(prev_beat));
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req_o) begin
                if (lat_cnt >= lat_target) begin
                    lat_cnt = 0;
                    lat_target = (lat_target + 1) % 3;
                    if (mem_we_o) begin
                        mem[int'(mem_addr_o[11:2])] = mem_wdata_o;
                        if (q_waddr.size() == 0) begin
                            chk(1'b0, "R8", "unexpected write", 256'(mem_addr_o), 256'd0);
                        end else begin
                            logic [31:0] ea, ed;
                            ea = q_waddr.pop_front();
                            ed = q_wdata.pop_front();
                            chk(mem_addr_o == ea, "R8", "write-back address", 256'(mem_addr_o), 256'(ea));
                            chk(mem_wdata_o == ed, "R8", "write-back status", 256'(mem_wdata_o), 256'(ed));
                        end
                    end else begin
                        mem_rdata = mem[int'(mem_addr_o[11:2])];
                    end
                    mem_ack = 1'b1;
                end else begin
                    lat_cnt++;
                end
            end
            m_tready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (mem_req_o) req_cycles++;
            if (m_tvalid_o && m_tready) begin
                if (q_bdata.size() == 0) begin
                    chk(1'b0, "R6", "unexpected beat", 256'(m_tdata_o), 256'd0);
                end else begin
                    logic [31:0] ed;
                    logic [3:0]  ek;
                    logic        el;
                    ed = q_bdata.pop_front();
                    ek = q_bkeep.pop_front();
                    el = q_blast.pop_front();
                    chk(m_tkeep_o == ek, "R6", "tkeep", 256'(m_tkeep_o), 256'(ek));
                    chk((m_tdata_o & lane_mask(ek)) == (ed & lane_mask(ek)), "R6", "tdata bytes",
                        256'(m_tdata_o & lane_mask(ek)), 256'(ed & lane_mask(ek)));
                    chk(m_tlast_o == el, "R6", "tlast", 256'(m_tlast_o), 256'(el));
                end
            end
            prev_stall = m_tvalid_o && !m_tready;
            prev_beat  = {m_tdata_o, m_tkeep_o, m_tlast_o, m_tvalid_o};
            if (cur_ptr_we_o) begin
                if (q_ptr.size() == 0) begin
                    chk(1'b0, "R9", "unexpected pointer update", 256'(cur_ptr_o), 256'd0);
                end else begin
                    logic [31:0] ep;
                    ep = q_ptr.pop_front();
                    chk(cur_ptr_o == ep, "R3 R9", "link pointer", 256'(cur_ptr_o), 256'(ep));
                end
                cur_reg = cur_ptr_o;
            end
            if (done_o) begin
                if (q_dbytes.size() == 0) begin
                    chk(1'b0, "R11", "unexpected completion", 256'(pkt_bytes_o), 256'd0);
                end else begin
                    logic [PW-1:0]    eb;
                    logic [UN*32-1:0] eu;
                    eb = q_dbytes.pop_front();
                    eu = q_duser.pop_front();
                    chk(pkt_bytes_o == eb, "R11", "packet bytes", 256'(pkt_bytes_o), 256'(eb));
                    chk(user_o == eu, "R5", "user words", 256'(user_o), 256'(eu));
                end
            end
            if (set_idle_o) begin
                seen_idle++;
                idle_reg = 1'b1;
                chk(seen_idle <= exp_idle, "R10", "extra set-idle", 256'(seen_idle), 256'(exp_idle));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

    initial begin
        for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_req_o && !m_tvalid_o && !done_o && !set_idle_o && !cur_ptr_we_o, "R1",
            "outputs in reset", 256'({mem_req_o, m_tvalid_o, done_o, set_idle_o, cur_ptr_we_o}), 256'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !m_tvalid_o && !done_o && !set_idle_o && !cur_ptr_we_o, "R1",
            "outputs after reset", 256'({mem_req_o, m_tvalid_o, done_o, set_idle_o, cur_ptr_we_o}), 256'd0);

        // Single whole-packet record, odd length
        put_desc(32'h100, 32'h140, 32'h400, ctl_word(1, 1, 10), 32'h0, 8'hA1);
        fill_buf(32'h400, 10, 8'h10);
        run_chain(32'h100, 32'h100, 1'b0);

        // R2: start while idle flag high, then while run enable low
        req_cycles = 0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        chk(req_cycles == 0, "R2", "start while idle", 256'(req_cycles), 256'd0);
        idle_reg = 1'b0;
        run_reg  = 1'b0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        chk(req_cycles == 0, "R2", "start while stopped", 256'(req_cycles), 256'd0);

        // Three-record packet under backpressure
        put_desc(32'h200, 32'h240, 32'h480, ctl_word(1, 0, 8), 32'h0, 8'hB2);
        put_desc(32'h240, 32'h280, 32'h4C0, ctl_word(0, 0, 5), 32'h0, 8'hB3);
        put_desc(32'h280, 32'h2C0, 32'h500, ctl_word(0, 1, 7), 32'h0, 8'hB4);
        fill_buf(32'h480, 8, 8'h20);
        fill_buf(32'h4C0, 5, 8'h40);
        fill_buf(32'h500, 7, 8'h60);
        run_chain(32'h200, 32'h280, 1'b1);

        // R4: chain stops at a record already complete
        put_desc(32'h300, 32'h340, 32'h540, ctl_word(1, 1, 4), 32'h0, 8'hC1);
        put_desc(32'h340, 32'h380, 32'h580, ctl_word(1, 1, 3), 32'h8000_0000, 8'hC2);
        fill_buf(32'h540, 4, 8'h80);
        fill_buf(32'h580, 3, 8'h90);
        run_chain(32'h300, 32'h380, 1'b0);
        chk(mem[int'(32'h35C >> 2)] == 32'h8000_0000, "R4", "complete record untouched",
            256'(mem[int'(32'h35C >> 2)]), 256'h8000_0000);
        chk(cur_reg == 32'h340, "R4", "pointer rests on complete record", 256'(cur_reg), 256'h340);

        // R12: zero-length record ahead of a short packet
        put_desc(32'h380, 32'h3C0, 32'h5C0, ctl_word(1, 1, 0), 32'h0, 8'hD1);
        put_desc(32'h3C0, 32'h000, 32'h5C0, ctl_word(1, 1, 3), 32'h0, 8'hD2);
        fill_buf(32'h5C0, 3, 8'hA0);
        run_chain(32'h380, 32'h3C0, 1'b0);
        chk(mem[int'(32'h39C >> 2)] == 32'h8000_0000, "R12", "zero-length status",
            256'(mem[int'(32'h39C >> 2)]), 256'h8000_0000);

        // R5: two packets in one chain restart count and user words
        put_desc(32'h000, 32'h040, 32'h600, ctl_word(1, 0, 6), 32'h0, 8'hE1);
        put_desc(32'h040, 32'h080, 32'h640, ctl_word(0, 1, 2), 32'h0, 8'hE2);
        put_desc(32'h080, 32'h0C0, 32'h680, ctl_word(1, 1, 9), 32'h0, 8'hE3);
        fill_buf(32'h600, 6, 8'h30);
        fill_buf(32'h640, 2, 8'h50);
        fill_buf(32'h680, 9, 8'h70);
        run_chain(32'h000, 32'h080, 1'b1);
        chk(cur_reg == 32'h0C0, "R9", "final current pointer", 256'(cur_reg), 256'h0C0);

        summary();
    end

endmodule